// File: doc/BRIEF.md
# Interrupt Moderation Timer

This unit sits between a DMA engine and its interrupt cause logic and thins out completion interrupts. Each of the two directions, transmit and receive, owns two moderation counters. A burst counter bounds how long a completion may wait before it is signalled. An idle counter signals early when the stream of completions pauses. Software programs each counter through a small write-only register port. The port sets a limit, an enable and a choice of time base: either the core clock or an external one-microsecond strobe.

Completions, the microsecond strobe and the receive high-threshold event are single-cycle strobes. They carry no payload and accept no back-pressure: a strobe is taken in the cycle it is high. Each moderated output is a one-cycle pulse, registered once. The receive high-threshold event bypasses moderation entirely. Receive buffers can therefore still be drained while a receive-done indication is being held back.

Top module: `irq_moderator`

## Requirements
- R1: After reset both done outputs and the high-threshold output are low, every counter is disabled and every threshold is zero.
- R2: While both counters of a direction are disabled, each completion gives a done pulse in the next cycle.
- R3: With only the burst counter enabled and a threshold T, the first completion that finds no completion pending starts the count. The done pulse appears after the (T+1)-th counted tick. Later completions do not restart the count.
- R4: With only the idle counter enabled and a threshold T, every completion restarts the count. A done pulse follows once T+1 ticks pass with no new completion.
- R5: When either counter of a moderated direction fires, exactly one done pulse is issued, the pending completion is consumed and both counts of that direction return to zero.
- R6: With the external-tick bit set, a counter advances only in cycles where us_tick is high. Otherwise it advances every clock cycle.
- R7: A control write with the clear bit set disables that counter and zeroes its count, whatever the other bits hold. Control bits: bit 0 enable, bit 1 external tick, bit 2 clear.
- R8: A threshold of zero fires on the first counted tick after a completion becomes pending.
- R9: rx_hthr is passed to rx_hthr_irq one cycle later, regardless of moderation state.
- R10: If both counters of a direction become disabled while a completion is pending, that completion is released as a done pulse in the next cycle.
- R11: Register address: bit 2 selects the direction (0 transmit, 1 receive), bit 1 the counter (0 burst, 1 idle), bit 0 the register (0 control, 1 threshold). Writes to one counter leave every other counter untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| us_tick | input | 1 | External microsecond strobe |
| tx_cmpl | input | 1 | Transmit completion strobe |
| rx_cmpl | input | 1 | Receive completion strobe |
| rx_hthr | input | 1 | Receive high-threshold event |
| tx_done | output | 1 | Moderated transmit done pulse |
| rx_done | output | 1 | Moderated receive done pulse |
| rx_hthr_irq | output | 1 | Unmoderated high-threshold pulse |

## Verification
Several properties are checked on every cycle. Pass-through timing holds when a direction is unmoderated. Every done pulse is traced back to a completion or a pending one. A done pulse with no fresh completion leaves nothing pending. An unmoderated direction never holds a completion. The high-threshold path copies its input one cycle later. The exact firing cycles cannot be checked per cycle: burst limits that ignore later completions, idle restarts, the external tick, zero thresholds and clear-bit priority. These are shown only by the bench's directed and random scenarios, compared against a reference model of the requirements.

// File: rtl/irq_moderator_pkg.sv
package irq_moderator_pkg;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_EXT_BIT = 1;
  localparam int CTRL_CLR_BIT = 2;
  localparam int NUM_DIRS     = 2;
  localparam int CNT_PER_DIR  = 2;

  typedef enum logic [1:0] {
    CNT_TX_BURST = 2'd0,
    CNT_TX_IDLE  = 2'd1,
    CNT_RX_BURST = 2'd2,
    CNT_RX_IDLE  = 2'd3
  } cnt_id_e;
endpackage

// File: rtl/imod_counter.sv
module imod_counter
  import irq_moderator_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int THR_W   = 16,
  parameter bit IS_IDLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_thr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              us_tick,
  input  logic              pending,
  input  logic              cmpl,
  input  logic              fire,
  output logic              hit,
  output logic              enabled
);
  logic             en_q, ext_q;
  logic [THR_W-1:0] thr_q, cnt_q;
  logic             tick_ok, restart;

  assign tick_ok = ext_q ? us_tick : 1'b1;

  generate
    if (IS_IDLE) begin : g_idle
      assign restart = cmpl;
    end else begin : g_burst
      assign restart = 1'b0;
    end
  endgenerate

  assign hit     = en_q & pending & tick_ok & ~restart & (cnt_q >= thr_q);
  assign enabled = en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      ext_q <= 1'b0;
      thr_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ctrl && wr_data[CTRL_CLR_BIT]) begin
        en_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        if (wr_ctrl) begin
          en_q  <= wr_data[CTRL_EN_BIT];
          ext_q <= wr_data[CTRL_EXT_BIT];
        end
        if (!pending || fire || restart) cnt_q <= '0;
        else if (en_q && tick_ok)         cnt_q <= cnt_q + 1'b1;
      end
      if (wr_thr) thr_q <= wr_data[THR_W-1:0];
    end
  end
endmodule

// File: rtl/imod_dir.sv
module imod_dir
  import irq_moderator_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int THR_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CNT_PER_DIR-1:0] wr_ctrl,
  input  logic [CNT_PER_DIR-1:0] wr_thr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   us_tick,
  input  logic                   cmpl,
  output logic                   done,
  output logic                   pend_o,
  output logic                   mod_o
);
  logic [CNT_PER_DIR-1:0] hit, en;
  logic                   fire, moderated, pend_q, done_q;

  assign fire      = |hit;
  assign moderated = |en;

  generate
    for (genvar k = 0; k < CNT_PER_DIR; k++) begin : g_cnt
      imod_counter #(
        .DATA_W (DATA_W),
        .THR_W  (THR_W),
        .IS_IDLE(k == 1)
      ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctrl(wr_ctrl[k]),
        .wr_thr (wr_thr[k]),
        .wr_data(wr_data),
        .us_tick(us_tick),
        .pending(pend_q),
        .cmpl   (cmpl),
        .fire   (fire),
        .hit    (hit[k]),
        .enabled(en[k])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= moderated ? fire : (cmpl | pend_q);
      if (!moderated) pend_q <= 1'b0;
      else if (cmpl)  pend_q <= 1'b1;
      else if (fire)  pend_q <= 1'b0;
    end
  end

  assign done   = done_q;
  assign pend_o = pend_q;
  assign mod_o  = moderated;
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irq_moderator_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int THR_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              us_tick,
  input  logic              tx_cmpl,
  input  logic              rx_cmpl,
  input  logic              rx_hthr,
  output logic              tx_done,
  output logic              rx_done,
  output logic              rx_hthr_irq
);
  logic [NUM_DIRS-1:0] cmpl_v, done_v, pend_v, mod_v;
  logic                hthr_q;

  assign cmpl_v = {rx_cmpl, tx_cmpl};

  generate
    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
      logic [CNT_PER_DIR-1:0] wc, wt;
      for (genvar k = 0; k < CNT_PER_DIR; k++) begin : g_dec
        localparam logic [1:0] SEL = 2'(d * CNT_PER_DIR + k);
        assign wc[k] = reg_wr && (reg_addr[2:1] == SEL) && !reg_addr[0];
        assign wt[k] = reg_wr && (reg_addr[2:1] == SEL) &&  reg_addr[0];
      end
      imod_dir #(.DATA_W(DATA_W), .THR_W(THR_W)) u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctrl(wc),
        .wr_thr (wt),
        .wr_data(reg_wdata),
        .us_tick(us_tick),
        .cmpl   (cmpl_v[d]),
        .done   (done_v[d]),
        .pend_o (pend_v[d]),
        .mod_o  (mod_v[d])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) hthr_q <= 1'b0;
    else        hthr_q <= rx_hthr;
  end

  assign tx_done     = done_v[0];
  assign rx_done     = done_v[1];
  assign rx_hthr_irq = hthr_q;
endmodule

// File: rtl/irq_moderator_chk.sv
module irq_moderator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmpl_v,
  input logic [1:0] done_v,
  input logic [1:0] pend_v,
  input logic [1:0] mod_v,
  input logic       rx_hthr,
  input logic       rx_hthr_irq
);
  generate
    for (genvar d = 0; d < 2; d++) begin : g_d
      assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_v[d] && cmpl_v[d]) |=> done_v[d]);
      assert_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_v[d] |-> $past(cmpl_v[d] | pend_v[d]));
      assert_consume_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_v[d] && !$past(cmpl_v[d])) |-> !pend_v[d]);
      assert_nohold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_v[d] |=> !pend_v[d]);
    end
  endgenerate

  assert_hthr_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hthr |=> rx_hthr_irq);
  assert_hthr_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_hthr |=> !rx_hthr_irq);
endmodule

bind irq_moderator irq_moderator_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmpl_v     (cmpl_v),
  .done_v     (done_v),
  .pend_v     (pend_v),
  .mod_v      (mod_v),
  .rx_hthr    (rx_hthr),
  .rx_hthr_irq(rx_hthr_irq)
);

// File: tb/test_irq_moderator.sv
module test_irq_moderator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        us_tick = 1'b0, tx_cmpl = 1'b0, rx_cmpl = 1'b0, rx_hthr = 1'b0;
  logic        tx_done, rx_done, rx_hthr_irq;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;

  // reference model state, indexed [direction][counter]
  bit m_en[2][2];
  bit m_ext[2][2];
  int m_thr[2][2];
  int m_cnt[2][2];
  bit m_pend[2];
  bit exp_done[2];
  bit exp_hthr;

  irq_moderator i_irq_moderator (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .us_tick(us_tick), .tx_cmpl(tx_cmpl),
    .rx_cmpl(rx_cmpl), .rx_hthr(rx_hthr), .tx_done(tx_done),
    .rx_done(rx_done), .rx_hthr_irq(rx_hthr_irq)
  );

  always #2 clk = ~clk;

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      m_pend[d] = 0; exp_done[d] = 0;
      for (int k = 0; k < 2; k++) begin
        m_en[d][k] = 0; m_ext[d][k] = 0; m_thr[d][k] = 0; m_cnt[d][k] = 0;
      end
    end
    exp_hthr = 0;
  endtask

  task automatic model_step(bit [1:0] cm, bit tk, bit wr, bit [2:0] ad, bit [31:0] wd);
    for (int d = 0; d < 2; d++) begin
      bit [1:0] hit;
      bit fire, modd, tko;
      modd = m_en[d][0] | m_en[d][1];
      for (int k = 0; k < 2; k++) begin
        tko = m_ext[d][k] ? tk : 1'b1;
        hit[k] = m_en[d][k] && m_pend[d] && tko && (m_cnt[d][k] >= m_thr[d][k])
                 && !(k == 1 && cm[d]);
      end
      fire = |hit;
      exp_done[d] = modd ? fire : (cm[d] | m_pend[d]);
      for (int k = 0; k < 2; k++) begin
        tko = m_ext[d][k] ? tk : 1'b1;
        if (!m_pend[d] || fire || (k == 1 && cm[d])) m_cnt[d][k] = 0;
        else if (m_en[d][k] && tko) m_cnt[d][k]++;
      end
      if (!modd) m_pend[d] = 0;
      else if (cm[d]) m_pend[d] = 1;
      else if (fire) m_pend[d] = 0;
    end
    if (wr) begin
      int d, k;
      d = ad[2]; k = ad[1];
      if (ad[0]) m_thr[d][k] = int'(wd[15:0]);
      else if (wd[2]) begin m_en[d][k] = 0; m_cnt[d][k] = 0; end
      else begin m_en[d][k] = wd[0]; m_ext[d][k] = wd[1]; end
    end
  endtask

  // one clock: drive at negedge, compare at the following negedge
  task automatic cyc(string tag, bit [1:0] cm, bit hth, bit tk,
                     bit wr = 0, bit [2:0] ad = 0, bit [31:0] wd = 0);
    tx_cmpl = cm[0]; rx_cmpl = cm[1]; rx_hthr = hth; us_tick = tk;
    reg_wr = wr; reg_addr = ad; reg_wdata = wd;
    model_step(cm, tk, wr, ad, wd);
    exp_hthr = hth;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " tx_done"}, tx_done, exp_done[0]);
    chk({tag, " rx_done"}, rx_done, exp_done[1]);
    chk({tag, " R9 hthr"}, rx_hthr_irq, exp_hthr);
  endtask

  task automatic wr_reg(string tag, bit [2:0] ad, bit [31:0] wd);
    cyc(tag, 2'b00, 0, 0, 1, ad, wd);
  endtask

  task automatic idle(string tag, int n, bit tk = 1);
    for (int i = 0; i < n; i++) cyc(tag, 2'b00, 0, tk);
  endtask

  // counts cycles until tx_done after a single completion (independent timing check)
  task automatic first_done(string tag, int expect_at);
    int found;
    found = 0;
    cyc(tag, 2'b01, 0, 1);
    for (int i = 1; i <= expect_at + 3; i++) begin
      cyc(tag, 2'b00, 0, 1);
      if (tx_done && found == 0) found = i;
    end
    n_chk++;
    if (found != expect_at) begin
      n_err++;
      $display("FAIL %s firing cycle actual=%0d expected=%0d", tag, found, expect_at);
    end
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    n_err++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = $urandom(20240611);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset tx_done", tx_done, 1'b0);
    chk("R1 reset rx_done", rx_done, 1'b0);
    chk("R1 reset hthr", rx_hthr_irq, 1'b0);
    rst_n = 1'b1;
    idle("R1 idle", 3);

    // R2 pass-through
    cyc("R2 tx", 2'b01, 0, 0);
    cyc("R2 both", 2'b11, 0, 0);
    cyc("R2 rx", 2'b10, 0, 0);
    cyc("R2 b2b", 2'b11, 0, 0);
    idle("R2 idle", 2);

    // R3 burst only, T=3, core clock
    wr_reg("R3 thr", 3'b001, 32'd3);
    wr_reg("R3 en", 3'b000, 32'h1);
    first_done("R3 single", 4);
    cyc("R3 c0", 2'b01, 0, 0);
    for (int i = 0; i < 6; i++) cyc("R3 stream", 2'b01, 0, 0);
    idle("R3 tail", 5);

    // R7 clear write dominates, then R4 idle only
    wr_reg("R7 clear", 3'b000, 32'h7);
    cyc("R7 pass", 2'b01, 0, 0);
    idle("R7 idle", 2);
    wr_reg("R4 thr", 3'b011, 32'd2);
    wr_reg("R4 en", 3'b010, 32'h1);
    for (int i = 0; i < 4; i++) begin
      cyc("R4 keep", 2'b01, 0, 0);
      cyc("R4 gap", 2'b00, 0, 0);
    end
    idle("R4 release", 5);

    // R8 zero threshold on idle counter
    wr_reg("R8 thr", 3'b011, 32'd0);
    first_done("R8 zero", 1);

    // R10 pending released when both disabled
    wr_reg("R10 thr", 3'b011, 32'd20);
    cyc("R10 c", 2'b01, 0, 0);
    idle("R10 wait", 3);
    wr_reg("R10 clr", 3'b010, 32'h4);
    idle("R10 after", 3);

    // R5 / R6 receive with both counters, burst on external tick
    wr_reg("R6 bthr", 3'b101, 32'd2);
    wr_reg("R6 ben", 3'b100, 32'h3);
    wr_reg("R5 ithr", 3'b111, 32'd6);
    wr_reg("R5 ien", 3'b110, 32'h1);
    for (int i = 0; i < 40; i++)
      cyc("R6 ext", {(i % 3 == 0), 1'b0}, (i % 7 == 0), (i % 5 == 4));
    idle("R5 drain", 12, 0);
    idle("R6 tick", 12, 1);

    // R11 random mix with writes across all counters
    for (int i = 0; i < 4000; i++) begin
      bit w;
      bit [2:0] a;
      bit [31:0] v;
      w = ($urandom_range(0, 19) == 0);
      a = 3'($urandom_range(0, 7));
      v = a[0] ? 32'($urandom_range(0, 6)) : 32'($urandom_range(0, 7));
      cyc("R11 rand", {($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0)},
          ($urandom_range(0, 9) == 0), ($urandom_range(0, 2) == 0), w, a, v);
    end
    idle("R11 end", 10);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule